// File: doc/BRIEF.md
# Register Window Pointer Controller

This block owns the pointer that selects the active window of a windowed general-purpose register file. A subroutine prologue asks it to step one window down (a save) and an epilogue asks it to step one window up (a restore). Each step is checked against two limits fixed at elaboration, a lowest and a highest legal window. When a step leaves the legal range, the block requests a trap. The trap code says whether the window file ran out downward (underflow) or upward (overflow).

Two other agents move the pointer. The control-register path may load it outright. That load is announced on a one-cycle hazard flag so that the pipeline can stall or flush. The exception controller may also ask for a one-window decrement on exception entry. A save also produces the new stack pointer from the frame pointer and a scaled word offset. The register file storage and the trap handler are outside this block.

Top module: `wpm_window_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer loads the high limit. `trap_req`, `trap_code`, `ctl_hazard` and `sp_we` all read zero after that edge.
- R2: A save that is not overridden sets the pointer to its old value minus one after the next edge. It also pulses `sp_we` for one cycle with `sp_wdata` = `fp_in` − 4 × `save_imm` (unsigned offset, modulo 2^32).
- R3: A restore with no decrement and no control write in the same cycle sets the pointer to its old value plus one.
- R4: A save issued while the old pointer equals the low limit raises `trap_req` for one cycle with `trap_code` = 1. The pointer is stepped exactly once, so it reads the low limit minus one.
- R5: A restore that is applied while the old pointer equals the high limit raises `trap_req` for one cycle with `trap_code` = 2. The pointer reads the high limit plus one.
- R6: An exception-entry decrement alone lowers the pointer by one and never raises a trap, even at the low limit.
- R7: A save and an exception-entry decrement in the same cycle lower the pointer by exactly one. The underflow check of the save still applies.
- R8: A control write loads `ctl_wdata` into the pointer and pulses `ctl_hazard` for one cycle. Any save, restore or decrement in the same cycle is ignored: no step, no trap, no `sp_we`.
- R9: A restore in the same cycle as a save or an exception decrement is ignored, and only the single decrement is applied.
- R10: A step away from the limits raises no trap. When `trap_req` is low, `trap_code` reads 0. The pointer wraps modulo 2^`CWP_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| save_req | input | 1 | Step one window down (prologue) |
| restore_req | input | 1 | Step one window up (epilogue) |
| exc_dec_req | input | 1 | Exception-entry decrement |
| ctl_we | input | 1 | Direct load of the pointer |
| ctl_wdata | input | CWP_W | Value for a direct load |
| fp_in | input | DATA_W | Current frame pointer |
| save_imm | input | IMM_W | Stack frame size in words for a save |
| cwp | output | CWP_W | Current window pointer |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 6 | 1 underflow, 2 overflow, else 0 |
| ctl_hazard | output | 1 | One-cycle flag after a direct load |
| sp_we | output | 1 | Stack pointer write strobe after a save |
| sp_wdata | output | DATA_W | New stack pointer value |

## Verification
The bench builds the block with a low limit of 2 and a high limit of 6. With these limits an overflow is reached in one restore after reset, and an underflow is reached after a short chain of saves. Direct loads then place the pointer at the low limit to exercise the collision cases: save with decrement, restore with decrement, and a load with a save. A load to zero followed by a decrement reaches the wrap of the 5-bit pointer.

// File: rtl/wpm_pkg.sv
package wpm_pkg;

    typedef enum logic [1:0] {
        WIN_HOLD = 2'd0,
        WIN_DEC  = 2'd1,
        WIN_INC  = 2'd2,
        WIN_LOAD = 2'd3
    } win_op_e;

    typedef struct packed {
        logic save;
        logic restore;
        logic exc_dec;
        logic ctl_wr;
    } win_req_t;

    typedef struct packed {
        win_op_e op;
        logic    chk_lo;
        logic    chk_hi;
        logic    sp_upd;
    } win_dec_t;

    localparam int TRAP_W = 6;
    localparam logic [TRAP_W-1:0] TRAP_NONE  = 6'd0;
    localparam logic [TRAP_W-1:0] TRAP_UNDER = 6'd1;
    localparam logic [TRAP_W-1:0] TRAP_OVER  = 6'd2;

    function automatic win_dec_t decode_req(input win_req_t r);
        win_dec_t d;
        d.op     = WIN_HOLD;
        d.chk_lo = 1'b0;
        d.chk_hi = 1'b0;
        d.sp_upd = 1'b0;
        if (r.ctl_wr) begin
            d.op = WIN_LOAD;
        end else if (r.save || r.exc_dec) begin
            d.op     = WIN_DEC;
            d.chk_lo = r.save;
            d.sp_upd = r.save;
        end else if (r.restore) begin
            d.op     = WIN_INC;
            d.chk_hi = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/wpm_arbiter.sv
module wpm_arbiter
    import wpm_pkg::*;
(
    input  logic     save_req,
    input  logic     restore_req,
    input  logic     exc_dec_req,
    input  logic     ctl_we,
    output win_dec_t dec
);
    win_req_t req;

    always_comb begin
        req.save    = save_req;
        req.restore = restore_req;
        req.exc_dec = exc_dec_req;
        req.ctl_wr  = ctl_we;
        dec         = decode_req(req);
    end

endmodule

// File: rtl/wpm_limit_check.sv
module wpm_limit_check
    import wpm_pkg::*;
#(
    parameter int CWP_W    = 5,
    parameter int LO_LIMIT = 1,
    parameter int HI_LIMIT = 14
) (
    input  logic [CWP_W-1:0]  cwp_old,
    input  logic              chk_lo,
    input  logic              chk_hi,
    output logic              hit,
    output logic [TRAP_W-1:0] code
);
    localparam logic [CWP_W-1:0] LO_V = CWP_W'(LO_LIMIT);
    localparam logic [CWP_W-1:0] HI_V = CWP_W'(HI_LIMIT);

    logic at_lo;
    logic at_hi;

    always_comb begin
        at_lo = (cwp_old == LO_V);
        at_hi = (cwp_old == HI_V);
        hit   = 1'b0;
        code  = TRAP_NONE;
        if (chk_lo && at_lo) begin
            hit  = 1'b1;
            code = TRAP_UNDER;
        end else if (chk_hi && at_hi) begin
            hit  = 1'b1;
            code = TRAP_OVER;
        end
    end

endmodule

// File: rtl/wpm_sp_calc.sv
module wpm_sp_calc #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [DATA_W-1:0] fp_in,
    input  logic [IMM_W-1:0]  imm,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_wdata
);
    localparam int PAD_W = DATA_W - IMM_W - 2;

    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] sp_next;

    always_comb begin
        offset  = {{PAD_W{1'b0}}, imm, 2'b00};
        sp_next = fp_in - offset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_we    <= 1'b0;
            sp_wdata <= '0;
        end else begin
            sp_we <= upd;
            if (upd) begin
                sp_wdata <= sp_next;
            end
        end
    end

endmodule

// File: rtl/wpm_window_ctrl.sv
module wpm_window_ctrl
    import wpm_pkg::*;
#(
    parameter int CWP_W    = 5,
    parameter int LO_LIMIT = 1,
    parameter int HI_LIMIT = 14,
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              save_req,
    input  logic              restore_req,
    input  logic              exc_dec_req,
    input  logic              ctl_we,
    input  logic [CWP_W-1:0]  ctl_wdata,
    input  logic [DATA_W-1:0] fp_in,
    input  logic [IMM_W-1:0]  save_imm,
    output logic [CWP_W-1:0]  cwp,
    output logic              trap_req,
    output logic [5:0]        trap_code,
    output logic              ctl_hazard,
    output logic              sp_we,
    output logic [DATA_W-1:0] sp_wdata
);
    localparam logic [CWP_W-1:0] LO_V  = CWP_W'(LO_LIMIT);
    localparam logic [CWP_W-1:0] HI_V  = CWP_W'(HI_LIMIT);
    localparam logic [CWP_W-1:0] ONE_V = CWP_W'(1);

    win_dec_t          dec;
    logic              hit;
    logic [TRAP_W-1:0] code;
    logic [CWP_W-1:0]  cwp_next;

    wpm_arbiter u_arb (
        .save_req    (save_req),
        .restore_req (restore_req),
        .exc_dec_req (exc_dec_req),
        .ctl_we      (ctl_we),
        .dec         (dec)
    );

    wpm_limit_check #(
        .CWP_W    (CWP_W),
        .LO_LIMIT (LO_LIMIT),
        .HI_LIMIT (HI_LIMIT)
    ) u_lim (
        .cwp_old (cwp),
        .chk_lo  (dec.chk_lo),
        .chk_hi  (dec.chk_hi),
        .hit     (hit),
        .code    (code)
    );

    wpm_sp_calc #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_sp (
        .clk      (clk),
        .rst      (rst),
        .upd      (dec.sp_upd),
        .fp_in    (fp_in),
        .imm      (save_imm),
        .sp_we    (sp_we),
        .sp_wdata (sp_wdata)
    );

    always_comb begin
        unique case (dec.op)
            WIN_DEC:  cwp_next = cwp - ONE_V;
            WIN_INC:  cwp_next = cwp + ONE_V;
            WIN_LOAD: cwp_next = ctl_wdata;
            default:  cwp_next = cwp;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp        <= HI_V;
            trap_req   <= 1'b0;
            trap_code  <= TRAP_NONE;
            ctl_hazard <= 1'b0;
        end else begin
            cwp        <= cwp_next;
            trap_req   <= hit;
            trap_code  <= code;
            ctl_hazard <= (dec.op == WIN_LOAD);
        end
    end

    // Assertions kept beside the pointer and trap registers they guard.
    assert_reset_val_R1: assert property (@(posedge clk)
        rst |=> (cwp == HI_V && !trap_req && !ctl_hazard && !sp_we));

    assert_save_step_R2: assert property (@(posedge clk) disable iff (rst)
        (save_req && !ctl_we) |=> (cwp == CWP_W'($past(cwp) - ONE_V) && sp_we));

    assert_restore_step_R3: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && !exc_dec_req && !ctl_we)
        |=> (cwp == CWP_W'($past(cwp) + ONE_V)));

    assert_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        (save_req && !ctl_we && cwp == LO_V)
        |=> (trap_req && trap_code == TRAP_UNDER && cwp == CWP_W'(LO_V - ONE_V)));

    assert_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && !exc_dec_req && !ctl_we && cwp == HI_V)
        |=> (trap_req && trap_code == TRAP_OVER));

    assert_exc_no_trap_R6: assert property (@(posedge clk) disable iff (rst)
        (exc_dec_req && !save_req && !ctl_we) |=> !trap_req);

    assert_load_hazard_R8: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_hazard && cwp == $past(ctl_wdata) && !trap_req && !sp_we));

    assert_code_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> (trap_code == TRAP_NONE));

endmodule

// File: tb/wpm_window_ctrl_tb.sv
module wpm_window_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CWP_W  = 5;
    localparam int LO     = 2;
    localparam int HI     = 6;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 8;
    localparam int WDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              save_req = 1'b0;
    logic              restore_req = 1'b0;
    logic              exc_dec_req = 1'b0;
    logic              ctl_we = 1'b0;
    logic [CWP_W-1:0]  ctl_wdata = '0;
    logic [DATA_W-1:0] fp_in = '0;
    logic [IMM_W-1:0]  save_imm = '0;
    logic [CWP_W-1:0]  cwp;
    logic              trap_req;
    logic [5:0]        trap_code;
    logic              ctl_hazard;
    logic              sp_we;
    logic [DATA_W-1:0] sp_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpm_window_ctrl #(
        .CWP_W(CWP_W), .LO_LIMIT(LO), .HI_LIMIT(HI),
        .DATA_W(DATA_W), .IMM_W(IMM_W)
    ) u_dut (
        .clk(clk), .rst(rst), .save_req(save_req), .restore_req(restore_req),
        .exc_dec_req(exc_dec_req), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .fp_in(fp_in), .save_imm(save_imm), .cwp(cwp), .trap_req(trap_req),
        .trap_code(trap_code), .ctl_hazard(ctl_hazard), .sp_we(sp_we),
        .sp_wdata(sp_wdata)
    );

    typedef struct {
        int                due;
        logic [CWP_W-1:0]  cwp;
        logic              trap;
        logic [5:0]        code;
        logic              hz;
        logic              spw;
        logic [DATA_W-1:0] sp;
        string             tag;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    logic [CWP_W-1:0] m_cwp;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver: one-cycle stimulus, expected result pushed for the next edge.
    task automatic step(input bit s, input bit r, input bit e, input bit w,
                        input logic [CWP_W-1:0] wd, input logic [DATA_W-1:0] fp,
                        input logic [IMM_W-1:0] imm, input string tag);
        exp_t x;
        @(negedge clk);
        save_req = s; restore_req = r; exc_dec_req = e; ctl_we = w;
        ctl_wdata = wd; fp_in = fp; save_imm = imm;
        x.due = cyc + 1; x.tag = tag;
        x.trap = 1'b0; x.code = 6'd0; x.hz = 1'b0; x.spw = 1'b0; x.sp = '0;
        if (w) begin
            x.cwp = wd; x.hz = 1'b1;
        end else if (s || e) begin
            x.cwp = m_cwp - 1'b1;
            if (s && m_cwp == CWP_W'(LO)) begin x.trap = 1'b1; x.code = 6'd1; end
            if (s) begin x.spw = 1'b1; x.sp = fp - DATA_W'({imm, 2'b00}); end
        end else if (r) begin
            x.cwp = m_cwp + 1'b1;
            if (m_cwp == CWP_W'(HI)) begin x.trap = 1'b1; x.code = 6'd2; end
        end else begin
            x.cwp = m_cwp;
        end
        m_cwp = x.cwp;
        sb.push_back(x);
    endtask

    // Monitor: compares at the falling edge after the registering edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t x;
            bit bad;
            x = sb.pop_front();
            checks++;
            bad = (cwp !== x.cwp) || (trap_req !== x.trap) || (trap_code !== x.code)
                || (ctl_hazard !== x.hz) || (sp_we !== x.spw)
                || (x.spw && sp_wdata !== x.sp);
            if (bad) begin
                fails++;
                $display("FAIL %s: got cwp=%0d trap=%0b code=%0d hz=%0b spw=%0b sp=%h exp cwp=%0d trap=%0b code=%0d hz=%0b spw=%0b sp=%h",
                    x.tag, cwp, trap_req, trap_code, ctl_hazard, sp_we, sp_wdata,
                    x.cwp, x.trap, x.code, x.hz, x.spw, x.sp);
            end
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (cwp !== CWP_W'(HI) || trap_req !== 1'b0 || trap_code !== 6'd0
            || ctl_hazard !== 1'b0 || sp_we !== 1'b0) begin
            fails++;
            $display("FAIL R1: got cwp=%0d trap=%0b hz=%0b spw=%0b exp cwp=%0d all flags 0",
                     cwp, trap_req, ctl_hazard, sp_we, HI);
        end
        m_cwp = CWP_W'(HI);

        step(0,0,0,0,0,0,0,"R1 idle after reset");
        step(0,1,0,0,0,0,0,"R5 restore at high limit");
        step(0,0,0,0,0,0,0,"R10 trap is one cycle");
        step(1,0,0,0,0,32'h0000_1000,8'd3,"R2 save with sp");
        step(1,0,0,0,0,32'h0000_0004,8'd2,"R2 save sp wraps");
        step(1,0,0,0,0,32'h8000_0000,8'hFF,"R10 save no trap");
        step(1,0,0,0,0,0,0,"R10 save no trap");
        step(1,0,0,0,0,0,0,"R2 save to low limit");
        step(1,0,0,0,0,32'h40,8'd1,"R4 underflow at low limit");
        step(0,0,0,0,0,0,0,"R4 single step and pulse");
        step(0,1,0,0,0,0,0,"R3 restore below limit");
        step(1,1,1,1,5'd10,32'h100,8'd1,"R8 load overrides all");
        step(1,0,0,1,5'(LO),0,0,"R8 load with save at limit");
        step(0,0,1,0,0,0,0,"R6 exc decrement at low limit");
        step(0,0,0,1,5'(LO),0,0,"R8 load to low limit");
        step(1,0,1,0,0,32'h200,8'd4,"R7 save plus exc single step");
        step(0,0,0,1,5'(HI),0,0,"R8 load to high limit");
        step(0,1,1,0,0,0,0,"R9 restore with decrement ignored");
        step(1,1,0,0,0,32'h300,8'd0,"R9 restore with save ignored");
        step(0,0,0,1,5'd0,0,0,"R8 load zero");
        step(0,0,1,0,0,0,0,"R10 wrap below zero");
        step(0,1,0,0,0,0,0,"R10 wrap above max");
        step(0,0,0,0,0,0,0,"R10 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule